// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This block turns the addressing fields of a load or store instruction into the address presented to data memory and the new value for the base register. The offset is either a zero-extended immediate or a register value that an upstream shifter has already shifted. The offset is added to or subtracted from the base. A two-bit index mode then decides which of two things happens. Either the access uses the unmodified base and the modified value is written back, or the access itself uses the modified value, which may also be written back.

The block also decodes the transfer direction and the transfer size. For a byte store it spreads the low byte of the source register over every lane and raises exactly one lane strobe. For a byte load it returns the addressed byte of the memory read word, zero-extended. One encoding of the index mode is reserved. That encoding raises an illegal flag and cancels both the memory strobe and the writeback. Results are registered by default, one cycle after a request.

Top module: `lsagu_top`

## Requirements
- R1: When `sel_reg` is 0, the offset is `imm_off` zero-extended to the address width.
- R2: When `sel_reg` is 1, the offset is `reg_off` taken unchanged.
- R3: When `up` is 1, the modified value is base plus offset; when `up` is 0 it is base minus offset, wrapping modulo 2^ADDR_W.
- R4: Post-index (`pre_idx`=0, `wb_bit`=0): `mem_addr` is the unmodified base, `wb_en` is 1 and `wb_val` is the modified value.
- R5: Offset mode (`pre_idx`=1, `wb_bit`=0): `mem_addr` is the modified value and `wb_en` is 0.
- R6: Pre-index (`pre_idx`=1, `wb_bit`=1): `mem_addr` and `wb_val` both equal the modified value and `wb_en` is 1.
- R7: `pre_idx`=0 with `wb_bit`=1 is reserved. It sets `bad_enc` to 1 and forces `mem_req`, `wb_en` and every `wr_mask` bit to 0.
- R8: `is_load` equals `load_acc` and `is_byte` equals `byte_acc`. The pair {load_acc, byte_acc} therefore means 00 store word, 01 store byte, 10 load word, 11 load byte.
- R9: For a store, a word access sets all `wr_mask` bits and `wr_data` = `store_src`. A byte access sets only mask bit `mem_addr[1:0]` (lane 0 = bits 7:0) and repeats `store_src[7:0]` in every lane. A load sets no mask bit.
- R10: `ld_val` is `rd_word` for a word load. For a byte load it is byte lane `mem_addr[1:0]` of `rd_word`, zero-extended. It follows `rd_word` in the same cycle.
- R11: A request on `req_valid` at one rising edge appears on the outputs after that edge. When `req_valid` was 0, `mem_req`, `wb_en` and `bad_enc` are 0 after the edge.
- R12: While `rst_n` is low, every registered output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A load/store request is present |
| base_val | input | ADDR_W | Base register value |
| imm_off | input | OFF_W | Immediate offset field |
| reg_off | input | ADDR_W | Pre-shifted register offset |
| sel_reg | input | 1 | 0: immediate offset, 1: register offset |
| pre_idx | input | 1 | Index-mode bit: apply offset before access |
| up | input | 1 | 1: add offset, 0: subtract |
| wb_bit | input | 1 | Index-mode bit: writeback request |
| byte_acc | input | 1 | 1: byte transfer, 0: word |
| load_acc | input | 1 | 1: load, 0: store |
| store_src | input | DATA_W | Source register value for stores |
| rd_word | input | DATA_W | Word read from memory |
| mem_req | output | 1 | Memory access strobe |
| mem_addr | output | ADDR_W | Effective address |
| is_load | output | 1 | Transfer direction |
| is_byte | output | 1 | Transfer size |
| bad_enc | output | 1 | Reserved index mode seen |
| wb_en | output | 1 | Base writeback enable |
| wb_val | output | ADDR_W | Base writeback value |
| wr_data | output | DATA_W | Store data with lanes placed |
| wr_mask | output | DATA_W/8 | Store byte-lane strobes |
| ld_val | output | DATA_W | Load result |

## Verification
Every output except `ld_val` comes from one register stage. The bench therefore drives a request on a falling edge, lets the next rising edge capture it, and samples on the falling edge after that. It lowers `req_valid` at that same point so that an idle cycle follows. `ld_val` depends on the registered address but is combinational in `rd_word`. It is checked a short delay after a new `rd_word` is driven in that same sampling half-cycle, with no further edge. Quiet outputs after an idle cycle are sampled one full cycle after the last request.

// File: rtl/lsagu_pkg.sv
`timescale 1ns/1ps
package lsagu_pkg;

   // Index mode, value is {pre_idx, wb_bit}
   typedef enum logic [1:0] {
      IDX_POST   = 2'b00,
      IDX_RSVD   = 2'b01,
      IDX_OFFSET = 2'b10,
      IDX_PRE    = 2'b11
   } idx_mode_e;

   typedef struct packed {
      logic is_load;
      logic is_byte;
      logic use_sum;   // access address is the modified base
      logic wb_req;    // modified base goes back to the register
      logic bad;       // reserved index mode
   } acc_ctl_t;

endpackage

// File: rtl/lsagu_mode_dec.sv
`timescale 1ns/1ps
module lsagu_mode_dec
   import lsagu_pkg::*;
(
   input  logic     pre_idx,
   input  logic     wb_bit,
   input  logic     byte_acc,
   input  logic     load_acc,
   output acc_ctl_t ctl
);

   idx_mode_e mode;

   assign mode = idx_mode_e'({pre_idx, wb_bit});

   always_comb begin
      ctl         = '0;
      ctl.is_load = load_acc;
      ctl.is_byte = byte_acc;
      unique case (mode)
         IDX_POST: begin
            ctl.use_sum = 1'b0;
            ctl.wb_req  = 1'b1;
         end
         IDX_OFFSET: begin
            ctl.use_sum = 1'b1;
            ctl.wb_req  = 1'b0;
         end
         IDX_PRE: begin
            ctl.use_sum = 1'b1;
            ctl.wb_req  = 1'b1;
         end
         IDX_RSVD: begin
            ctl.bad     = 1'b1;
         end
         default: ctl.bad = 1'b1;
      endcase
   end

endmodule

// File: rtl/lsagu_ea.sv
`timescale 1ns/1ps
module lsagu_ea #(
   parameter int ADDR_W         = 32,
   parameter int OFF_W          = 12,
   parameter bit SUB_VIA_INVERT = 1'b1
) (
   input  logic [ADDR_W-1:0] base_val,
   input  logic [OFF_W-1:0]  imm_off,
   input  logic [ADDR_W-1:0] reg_off,
   input  logic              sel_reg,
   input  logic              up,
   output logic [ADDR_W-1:0] sum
);

   localparam int PAD_W = ADDR_W - OFF_W;

   logic [ADDR_W-1:0] offset;

   // immediate is zero-extended, register offset arrives already shifted
   assign offset = sel_reg ? reg_off : {{PAD_W{1'b0}}, imm_off};

   generate
      if (SUB_VIA_INVERT) begin : g_one_adder
         logic [ADDR_W-1:0] opnd;
         assign opnd = offset ^ {ADDR_W{~up}};
         assign sum  = base_val + opnd + {{(ADDR_W-1){1'b0}}, ~up};
      end else begin : g_two_adders
         logic [ADDR_W-1:0] add_r;
         logic [ADDR_W-1:0] sub_r;
         assign add_r = base_val + offset;
         assign sub_r = base_val - offset;
         assign sum   = up ? add_r : sub_r;
      end
   endgenerate

endmodule

// File: rtl/lsagu_store_lane.sv
`timescale 1ns/1ps
module lsagu_store_lane #(
   parameter int DATA_W = 32,
   parameter int BYTE_W = 8,
   localparam int LANES = DATA_W / BYTE_W,
   localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic              is_byte,
   input  logic              is_load,
   input  logic              enable,
   input  logic [SEL_W-1:0]  lane_sel,
   input  logic [DATA_W-1:0] store_src,
   output logic [DATA_W-1:0] wr_data,
   output logic [LANES-1:0]  wr_mask
);

   assign wr_data = is_byte ? {LANES{store_src[BYTE_W-1:0]}} : store_src;

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_mask
         assign wr_mask[g] = enable & ~is_load &
                             (~is_byte | (lane_sel == SEL_W'(g)));
      end
   endgenerate

endmodule

// File: rtl/lsagu_load_lane.sv
`timescale 1ns/1ps
module lsagu_load_lane #(
   parameter int DATA_W = 32,
   parameter int BYTE_W = 8,
   localparam int LANES = DATA_W / BYTE_W,
   localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic              is_byte,
   input  logic [SEL_W-1:0]  lane_sel,
   input  logic [DATA_W-1:0] rd_word,
   output logic [DATA_W-1:0] ld_val
);

   logic [BYTE_W-1:0] picked;

   always_comb begin
      picked = '0;
      for (int i = 0; i < LANES; i++) begin
         if (lane_sel == SEL_W'(i)) picked = rd_word[i*BYTE_W +: BYTE_W];
      end
   end

   assign ld_val = is_byte ? {{(DATA_W-BYTE_W){1'b0}}, picked} : rd_word;

endmodule

// File: rtl/lsagu_top.sv
`timescale 1ns/1ps
module lsagu_top
   import lsagu_pkg::*;
#(
   parameter int ADDR_W         = 32,
   parameter int OFF_W          = 12,
   parameter int DATA_W         = 32,
   parameter int BYTE_W         = 8,
   parameter bit SUB_VIA_INVERT = 1'b1,
   parameter bit OUT_REG        = 1'b1,
   localparam int LANES         = DATA_W / BYTE_W,
   localparam int SEL_W         = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] base_val,
   input  logic [OFF_W-1:0]  imm_off,
   input  logic [ADDR_W-1:0] reg_off,
   input  logic              sel_reg,
   input  logic              pre_idx,
   input  logic              up,
   input  logic              wb_bit,
   input  logic              byte_acc,
   input  logic              load_acc,
   input  logic [DATA_W-1:0] store_src,
   input  logic [DATA_W-1:0] rd_word,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              is_load,
   output logic              is_byte,
   output logic              bad_enc,
   output logic              wb_en,
   output logic [ADDR_W-1:0] wb_val,
   output logic [DATA_W-1:0] wr_data,
   output logic [LANES-1:0]  wr_mask,
   output logic [DATA_W-1:0] ld_val
);

   // elaboration-time parameter checks
   generate
      if (OFF_W >= ADDR_W) begin : g_err_off
         $error("lsagu_top: OFF_W must be narrower than ADDR_W");
      end
      if (DATA_W % BYTE_W != 0) begin : g_err_lane
         $error("lsagu_top: DATA_W must be a multiple of BYTE_W");
      end
      if ((LANES & (LANES - 1)) != 0) begin : g_err_pow2
         $error("lsagu_top: lane count must be a power of two");
      end
      if (SEL_W > ADDR_W) begin : g_err_sel
         $error("lsagu_top: address too narrow for lane select");
      end
   endgenerate

   acc_ctl_t          ctl;
   logic [ADDR_W-1:0] sum;
   logic [ADDR_W-1:0] n_addr;
   logic              n_go;
   logic              n_bad;
   logic              n_wb;
   logic [DATA_W-1:0] n_wr_data;
   logic [LANES-1:0]  n_wr_mask;

   lsagu_mode_dec u_dec (
      .pre_idx  (pre_idx),
      .wb_bit   (wb_bit),
      .byte_acc (byte_acc),
      .load_acc (load_acc),
      .ctl      (ctl)
   );

   lsagu_ea #(
      .ADDR_W         (ADDR_W),
      .OFF_W          (OFF_W),
      .SUB_VIA_INVERT (SUB_VIA_INVERT)
   ) u_ea (
      .base_val (base_val),
      .imm_off  (imm_off),
      .reg_off  (reg_off),
      .sel_reg  (sel_reg),
      .up       (up),
      .sum      (sum)
   );

   assign n_addr = ctl.use_sum ? sum : base_val;
   assign n_go   = req_valid & ~ctl.bad;
   assign n_bad  = req_valid & ctl.bad;
   assign n_wb   = n_go & ctl.wb_req;

   lsagu_store_lane #(
      .DATA_W (DATA_W),
      .BYTE_W (BYTE_W)
   ) u_st (
      .is_byte   (ctl.is_byte),
      .is_load   (ctl.is_load),
      .enable    (n_go),
      .lane_sel  (n_addr[SEL_W-1:0]),
      .store_src (store_src),
      .wr_data   (n_wr_data),
      .wr_mask   (n_wr_mask)
   );

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               mem_req  <= 1'b0;
               mem_addr <= '0;
               is_load  <= 1'b0;
               is_byte  <= 1'b0;
               bad_enc  <= 1'b0;
               wb_en    <= 1'b0;
               wb_val   <= '0;
               wr_data  <= '0;
               wr_mask  <= '0;
            end else begin
               mem_req  <= n_go;
               mem_addr <= n_addr;
               is_load  <= ctl.is_load;
               is_byte  <= ctl.is_byte;
               bad_enc  <= n_bad;
               wb_en    <= n_wb;
               wb_val   <= sum;
               wr_data  <= n_wr_data;
               wr_mask  <= n_wr_mask;
            end
         end
      end else begin : g_comb
         assign mem_req  = n_go;
         assign mem_addr = n_addr;
         assign is_load  = ctl.is_load;
         assign is_byte  = ctl.is_byte;
         assign bad_enc  = n_bad;
         assign wb_en    = n_wb;
         assign wb_val   = sum;
         assign wr_data  = n_wr_data;
         assign wr_mask  = n_wr_mask;
      end
   endgenerate

   lsagu_load_lane #(
      .DATA_W (DATA_W),
      .BYTE_W (BYTE_W)
   ) u_ld (
      .is_byte  (is_byte),
      .lane_sel (mem_addr[SEL_W-1:0]),
      .rd_word  (rd_word),
      .ld_val   (ld_val)
   );

endmodule

// File: rtl/lsagu_chk.sv
`timescale 1ns/1ps
module lsagu_chk #(
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 32,
   parameter int BYTE_W  = 8,
   parameter bit OUT_REG = 1'b1,
   localparam int LANES  = DATA_W / BYTE_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [ADDR_W-1:0] base_val,
   input logic              pre_idx,
   input logic              wb_bit,
   input logic              byte_acc,
   input logic              load_acc,
   input logic              mem_req,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              is_load,
   input logic              is_byte,
   input logic              bad_enc,
   input logic              wb_en,
   input logic [ADDR_W-1:0] wb_val,
   input logic [LANES-1:0]  wr_mask,
   input logic [DATA_W-1:0] ld_val
);

   // R7
   bad_enc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bad_enc |-> (!mem_req && !wb_en && wr_mask == '0));

   // R10
   ld_byte_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_byte |-> ld_val[DATA_W-1:BYTE_W] == '0);

   // R9
   load_no_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && is_load) |-> wr_mask == '0);

   // R9
   byte_one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !is_load && is_byte) |-> $countones(wr_mask) == 1);

   generate
      if (OUT_REG) begin : g_seq
         // R11
         idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(req_valid) |-> (!mem_req && !wb_en && !bad_enc));

         // R4
         post_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(req_valid && !pre_idx && !wb_bit) |->
               (wb_en && mem_addr == $past(base_val)));

         // R5
         offset_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(req_valid && pre_idx && !wb_bit) |-> (mem_req && !wb_en));

         // R6
         pre_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(req_valid && pre_idx && wb_bit) |-> (wb_en && wb_val == mem_addr));

         // R8
         dir_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
            mem_req |-> (is_load == $past(load_acc) && is_byte == $past(byte_acc)));
      end
   endgenerate

endmodule

bind lsagu_top lsagu_chk #(
   .ADDR_W  (ADDR_W),
   .DATA_W  (DATA_W),
   .BYTE_W  (BYTE_W),
   .OUT_REG (OUT_REG)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .base_val  (base_val),
   .pre_idx   (pre_idx),
   .wb_bit    (wb_bit),
   .byte_acc  (byte_acc),
   .load_acc  (load_acc),
   .mem_req   (mem_req),
   .mem_addr  (mem_addr),
   .is_load   (is_load),
   .is_byte   (is_byte),
   .bad_enc   (bad_enc),
   .wb_en     (wb_en),
   .wb_val    (wb_val),
   .wr_mask   (wr_mask),
   .ld_val    (ld_val)
);

// File: tb/tb_lsagu_top.sv
`timescale 1ns/1ps
module tb_lsagu_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] base_val = '0;
   logic [11:0] imm_off = '0;
   logic [31:0] reg_off = '0;
   logic        sel_reg = 1'b0;
   logic        pre_idx = 1'b0;
   logic        up = 1'b0;
   logic        wb_bit = 1'b0;
   logic        byte_acc = 1'b0;
   logic        load_acc = 1'b0;
   logic [31:0] store_src = '0;
   logic [31:0] rd_word = '0;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        is_load;
   logic        is_byte;
   logic        bad_enc;
   logic        wb_en;
   logic [31:0] wb_val;
   logic [31:0] wr_data;
   logic [3:0]  wr_mask;
   logic [31:0] ld_val;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   lsagu_top dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .base_val(base_val),
      .imm_off(imm_off), .reg_off(reg_off), .sel_reg(sel_reg), .pre_idx(pre_idx),
      .up(up), .wb_bit(wb_bit), .byte_acc(byte_acc), .load_acc(load_acc),
      .store_src(store_src), .rd_word(rd_word), .mem_req(mem_req),
      .mem_addr(mem_addr), .is_load(is_load), .is_byte(is_byte),
      .bad_enc(bad_enc), .wb_en(wb_en), .wb_val(wb_val), .wr_data(wr_data),
      .wr_mask(wr_mask), .ld_val(ld_val)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] f_off(logic i, logic [11:0] imm, logic [31:0] r);
      return i ? r : {20'b0, imm};
   endfunction

   function automatic logic [31:0] f_sum(logic [31:0] b, logic [31:0] o, logic u);
      return u ? b + o : b - o;
   endfunction

   function automatic logic [31:0] f_byte(logic [31:0] w, logic [1:0] s);
      return {24'b0, w[s*8 +: 8]};
   endfunction

   task automatic do_req(input logic [31:0] b, input logic [11:0] imm,
                         input logic [31:0] r, input logic i, input logic p,
                         input logic u, input logic w, input logic bb,
                         input logic l, input logic [31:0] src,
                         input logic [31:0] rdw);
      logic [31:0] s, ea;
      logic        bad, wbe;
      logic [3:0]  msk;
      s   = f_sum(b, f_off(i, imm, r), u);
      bad = !p && w;
      ea  = p ? s : b;
      wbe = !bad && (w || !p);
      if (bad || l) msk = 4'h0;
      else if (bb)  msk = 4'h1 << ea[1:0];
      else          msk = 4'hF;
      @(negedge clk);
      base_val = b; imm_off = imm; reg_off = r; sel_reg = i; pre_idx = p;
      up = u; wb_bit = w; byte_acc = bb; load_acc = l; store_src = src;
      req_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      // R7 illegal flag and suppression
      chk("R7 bad_enc", {31'b0, bad_enc}, {31'b0, bad});
      chk("R7 mem_req", {31'b0, mem_req}, {31'b0, !bad});
      // R4 R5 R6 writeback enable per index mode
      chk("R4/R5/R6 wb_en", {31'b0, wb_en}, {31'b0, wbe});
      chk("R9 wr_mask", {28'b0, wr_mask}, {28'b0, msk});
      if (!bad) begin
         // R1 R2 R3 address and writeback value
         chk("R3 mem_addr", mem_addr, ea);
         chk("R3 wb_val", wb_val, s);
         chk("R8 is_load", {31'b0, is_load}, {31'b0, l});
         chk("R8 is_byte", {31'b0, is_byte}, {31'b0, bb});
         if (!l) chk("R9 wr_data", wr_data, bb ? {4{src[7:0]}} : src);
         rd_word = rdw;
         #1;
         chk("R10 ld_val", ld_val, bb ? f_byte(rdw, ea[1:0]) : rdw);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R12 reset state
      chk("R12 mem_req", {31'b0, mem_req}, 32'd0);
      chk("R12 wb_en", {31'b0, wb_en}, 32'd0);
      chk("R12 bad_enc", {31'b0, bad_enc}, 32'd0);
      chk("R12 mem_addr", mem_addr, 32'd0);
      chk("R12 wr_mask", {28'b0, wr_mask}, 32'd0);
      rst_n = 1'b1;

      // R4 R3 R1 post-index store word, subtract 26 from base 1000
      do_req(32'd1000, 12'd26, 32'h0, 0, 0, 0, 0, 0, 0, 32'hCAFEF00D, 32'h0);
      chk("R4 post wb_val", wb_val, 32'd974);
      // R6 R3 pre-index subtraction wraps below zero
      do_req(32'd5, 12'd10, 32'h0, 0, 1, 0, 1, 0, 1, 32'h0, 32'h11223344);
      chk("R6 wrap", mem_addr, 32'hFFFFFFFB);
      // R1 immediate zero-extended, largest value
      do_req(32'h1000, 12'hFFF, 32'h0, 0, 1, 1, 0, 0, 1, 32'h0, 32'h55AA55AA);
      chk("R1 zext", mem_addr, 32'h1FFF);
      // R2 register offset ignores immediate
      do_req(32'h100, 12'h7FF, 32'h80000000, 1, 1, 1, 0, 1, 1, 32'h0, 32'h89ABCDEF);
      chk("R2 regoff", mem_addr, 32'h80000100);
      // R7 reserved mode, both with load and store
      do_req(32'h40, 12'd4, 32'h0, 0, 0, 1, 1, 0, 0, 32'hFFFFFFFF, 32'h0);
      do_req(32'h40, 12'd4, 32'h0, 1, 0, 1, 1, 1, 1, 32'h0, 32'h0);
      // R9 R10 every byte lane for byte store and byte load
      for (int k = 0; k < 4; k++) begin
         do_req(32'h200 + k, 12'd0, 32'h0, 0, 1, 1, 0, 1, 0, 32'h123456A5, 32'h0);
         do_req(32'h300, k[11:0], 32'h0, 0, 1, 1, 1, 1, 1, 32'h0, 32'hF1E2D3C4);
      end
      // R11 idle cycle after a request leaves strobes low
      @(negedge clk);
      chk("R11 idle mem_req", {31'b0, mem_req}, 32'd0);
      chk("R11 idle wb_en", {31'b0, wb_en}, 32'd0);
      chk("R11 idle bad_enc", {31'b0, bad_enc}, 32'd0);

      // random mix
      for (int n = 0; n < 600; n++) begin
         logic [31:0] rb, rr, rs, rw;
         logic [11:0] ri;
         logic [5:0]  bits;
         rb = $urandom; rr = $urandom; rs = $urandom; rw = $urandom;
         ri = 12'($urandom);
         bits = 6'($urandom);
         do_req(rb, ri, rr, bits[0], bits[1], bits[2], bits[3], bits[4], bits[5], rs, rw);
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule